// File: doc/BRIEF.md
# Speculation Recovery Sequencer

This controller sequences a datapath that runs one loop step per clock on a speculated branch outcome. After a start request it waits for the pipeline to prime. It then commits one speculated result per cycle. When the validation stage flags a misspeculation, it holds the datapath idle for a fixed wait. It then spends one cycle committing the recovered value and rolling back the history buffers, and primes the pipeline again. The strobes it produces gate the result registers and the history buffers of the datapath. The datapath itself, the condition logic and the buffers are not part of this block.

Two parameters set the phase lengths. `PRIME_CYC` is the priming length, which is the validate latency minus one. `WAIT_CYC` is the wait length, which is the recovery-path latency minus the validate latency minus one. A single down-counter times both phases. Two event counters record the committed iterations and the misspeculations, so a bench can derive the effective initiation interval. A done input is honoured only in a cycle that commits. It returns the block to idle and drops any iterations that were not committed.

Top module: `spec_recovery_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the block idle. In that state commit, rollback and path_sel are 0, and both event counters read 0.
- R2: While idle, a start pulse begins a priming phase that lasts exactly PRIME_CYC cycles. All strobes are 0 during priming. A start that arrives while the block is not idle has no effect.
- R3: In the steady state, every cycle without a misspeculation asserts commit, with path_sel=1 (1 selects the speculated value, 0 selects the recovery value) and rollback=0. This gives one commit per cycle.
- R4: A misspeculation flag in a steady-state cycle suppresses commit in that cycle. It is followed by exactly WAIT_CYC cycles in which all strobes are 0.
- R5: After the wait, exactly one recovery cycle asserts commit=1 and rollback=1 with path_sel=0. A new priming phase of PRIME_CYC cycles follows it.
- R6: The gap from a misspeculated cycle to the next steady-state commit is WAIT_CYC+PRIME_CYC+2 cycles.
- R7: The misspeculation flag is ignored outside the steady state. It changes neither the strobes, nor the phase timing, nor the misspeculation counter.
- R8: Done together with a steady-state commit returns the block to idle on the next cycle. Done in a cycle without commit is ignored. A misspeculated cycle does not commit, so done has no effect in that cycle.
- R9: commit_count adds one for every cycle with commit=1. miss_count adds one for every honoured misspeculation. Both counters clear when a start is accepted.
- R10: Done during the recovery cycle returns the block to idle instead of starting a new priming phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, honoured only when idle |
| misspec | input | 1 | Misspeculation flag from the validation stage |
| done | input | 1 | Loop exit, honoured only with commit |
| commit | output | 1 | Commit strobe for the result registers |
| rollback | output | 1 | Rollback strobe for the history buffers |
| path_sel | output | 1 | 1 selects the speculated value, 0 selects the recovery value |
| commit_count | output | CNT_W | Committed iterations since start |
| miss_count | output | CNT_W | Misspeculations since start |

## Verification
A wrong phase register shows up at the ports within one cycle. The commit, rollback and path_sel strobes are a distinct pattern in each phase, except that idle, priming and waiting all drive zeros. Those three phases can only be told apart by when the next commit appears. For that reason every priming and wait length is timed to the exact cycle. A counter loaded with the wrong value shifts the first commit or the recovery cycle by at least one cycle. A missed or extra event shows in the counters from the next cycle on.

// File: rtl/spec_recovery_ctrl.sv
module spec_recovery_ctrl #(
  parameter int PRIME_CYC = 1,
  parameter int WAIT_CYC  = 2,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             misspec,
  input  logic             done,
  output logic             commit,
  output logic             rollback,
  output logic             path_sel,
  output logic [CNT_W-1:0] commit_count,
  output logic [CNT_W-1:0] miss_count
);
  localparam int LONGEST = (PRIME_CYC > WAIT_CYC) ? PRIME_CYC : WAIT_CYC;
  localparam int TMR_W   = $clog2(LONGEST + 1);
  localparam logic [TMR_W-1:0] PRIME_LOAD = TMR_W'(PRIME_CYC - 1);
  localparam logic [TMR_W-1:0] WAIT_LOAD  = TMR_W'(WAIT_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_PRIME, S_SPEC, S_WAIT, S_RECOV} phase_t;

  phase_t           phase;
  logic [TMR_W-1:0] tmr;

  wire in_spec  = (phase == S_SPEC);
  wire in_recov = (phase == S_RECOV);
  wire tmr_zero = (tmr == '0);
  wire miss_hit = in_spec && misspec;

  assign path_sel = in_spec;
  assign rollback = in_recov;
  assign commit   = (in_spec && !misspec) || in_recov;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= S_IDLE;
      tmr   <= '0;
    end else begin
      case (phase)
        S_IDLE:
          if (start) begin
            phase <= S_PRIME;
            tmr   <= PRIME_LOAD;
          end
        S_PRIME:
          if (tmr_zero) phase <= S_SPEC;
          else          tmr   <= tmr - 1'b1;
        S_SPEC:
          if (misspec) begin
            phase <= S_WAIT;
            tmr   <= WAIT_LOAD;
          end else if (done) begin
            phase <= S_IDLE;
          end
        S_WAIT:
          if (tmr_zero) phase <= S_RECOV;
          else          tmr   <= tmr - 1'b1;
        S_RECOV:
          if (done) begin
            phase <= S_IDLE;
          end else begin
            phase <= S_PRIME;
            tmr   <= PRIME_LOAD;
          end
        default: phase <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || (phase == S_IDLE && start)) begin
      commit_count <= '0;
      miss_count   <= '0;
    end else begin
      if (commit)   commit_count <= commit_count + 1'b1;
      if (miss_hit) miss_count   <= miss_count + 1'b1;
    end
  end
endmodule

// File: rtl/spec_recovery_ctrl_chk.sv
module spec_recovery_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             misspec,
  input logic             done,
  input logic             commit,
  input logic             rollback,
  input logic             path_sel,
  input logic [CNT_W-1:0] commit_count,
  input logic [CNT_W-1:0] miss_count
);
  p_recov_strobes_r5: assert property (@(posedge clk) disable iff (rst)
    rollback |-> (commit && !path_sel));

  p_spec_no_rollback_r3: assert property (@(posedge clk) disable iff (rst)
    path_sel |-> !rollback);

  p_recov_then_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (rollback && !done) |=> (!commit && !rollback));

  p_miss_then_wait_r4: assert property (@(posedge clk) disable iff (rst)
    (path_sel && misspec) |=> (!commit && !rollback && !path_sel));

  p_done_to_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (commit && done) |=> (!commit && !rollback && !path_sel));

  p_commit_counted_r9: assert property (@(posedge clk) disable iff (rst)
    commit |=> (commit_count == $past(commit_count) + 1'b1));

  p_miss_counted_r9: assert property (@(posedge clk) disable iff (rst)
    (path_sel && misspec) |=> (miss_count == $past(miss_count) + 1'b1));

  p_one_strobe_kind_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({path_sel, rollback}));
endmodule

bind spec_recovery_ctrl spec_recovery_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .misspec(misspec), .done(done),
  .commit(commit), .rollback(rollback), .path_sel(path_sel),
  .commit_count(commit_count), .miss_count(miss_count)
);

// File: tb/tb_spec_recovery_ctrl.sv
module tb_spec_recovery_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PC = 2;
  localparam int WC = 3;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, misspec = 1'b0, done = 1'b0;
  logic commit, rollback, path_sel;
  logic [CW-1:0] commit_count, miss_count;

  int checks = 0;
  int errors = 0;
  int exp_cc = 0;
  int exp_mc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_recovery_ctrl #(.PRIME_CYC(PC), .WAIT_CYC(WC), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .start(start), .misspec(misspec), .done(done),
    .commit(commit), .rollback(rollback), .path_sel(path_sel),
    .commit_count(commit_count), .miss_count(miss_count)
  );

  task automatic cyc(input logic s, input logic m, input logic d,
                     input logic ec, input logic er, input logic es,
                     input bit miss_inc, input bit clr, input string tag);
    @(negedge clk);
    start = s; misspec = m; done = d;
    #1;
    checks++;
    if ({commit, rollback, path_sel} !== {ec, er, es}) begin
      errors++;
      $display("FAIL %s strobes c/r/s got %b%b%b exp %b%b%b", tag,
               commit, rollback, path_sel, ec, er, es);
    end
    checks++;
    if (int'(commit_count) != exp_cc || int'(miss_count) != exp_mc) begin
      errors++;
      $display("FAIL R9 (%s) counts got %0d/%0d exp %0d/%0d", tag,
               commit_count, miss_count, exp_cc, exp_mc);
    end
    if (clr) begin
      exp_cc = 0; exp_mc = 0;
    end else begin
      exp_cc += int'(ec);
      exp_mc += int'(miss_inc);
    end
  endtask

  task automatic prime_phase(input string tag);
    for (int i = 0; i < PC; i++) cyc(1'b1, 1'b1, 1'b1, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wait_phase(input string tag);
    for (int i = 0; i < WC; i++) cyc(1'b1, 1'b1, 1'b1, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1 reset idle");
    cyc(0, 1, 1, 0, 0, 0, 0, 0, "R7 misspec/done in idle");
    cyc(1, 0, 0, 0, 0, 0, 0, 1, "R2 start accepted");
    prime_phase("R2/R7 priming ignores start/misspec/done");
    cyc(0, 0, 0, 1, 0, 1, 0, 0, "R3 first commit");

    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < k; j++) cyc(j[0], 0, 0, 1, 0, 1, 0, 0, "R3/R2 steady commit");
      cyc(0, 1, 1, 0, 0, 1, 1, 0, "R4/R8 misspec suppresses commit and done");
      wait_phase("R4/R7 wait quiet");
      cyc(0, 0, 0, 1, 1, 0, 0, 0, "R5 recovery cycle");
      prime_phase("R5/R6 re-prime");
      cyc(0, 0, 0, 1, 0, 1, 0, 0, "R6 commit after penalty");
    end

    cyc(0, 0, 1, 1, 0, 1, 0, 0, "R8 done with commit");
    for (int i = 0; i < PC + 3; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, "R8 idle after done");

    cyc(1, 0, 0, 0, 0, 0, 0, 1, "R9 restart clears counters");
    prime_phase("R2 priming");
    cyc(0, 0, 0, 1, 0, 1, 0, 0, "R3 commit");
    cyc(0, 1, 0, 0, 0, 1, 1, 0, "R4 misspec");
    wait_phase("R4 wait");
    cyc(0, 0, 1, 1, 1, 0, 0, 0, "R10 done in recovery");
    for (int i = 0; i < PC + 3; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, "R10 idle after recovery done");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule